// File: doc/BRIEF.md
# UART Receive Error-Flag Controller

This block is the register-side companion of one UART receive channel. A receiver core, which does the bit sampling and baud timing elsewhere, reports each completed character with a one-cycle `rx_done` pulse, the received byte, and two quality indications: a bad parity bit and a bad stop bit. The block latches the byte into a data register and raises a buffer-full flag. It raises parity, framing and overrun error flags as events arrive, and it owns the channel's run/stop state.

Software talks to the block over a simple synchronous register bus. A read is combinational, and its side effect takes place at the clock edge. A write takes effect at the clock edge. Software drains the byte through the data register. It reads the error type from a status register whose reads have no side effects. It acknowledges errors by writing the status value it read back into a separate write-one-to-clear register. After a framing error, software stops the channel, resynchronises with the far end, and starts the channel again. It does this through self-clearing start and stop trigger bits. The resulting state is visible on the `chan_en` output and in a run-status register.

Top module: `uart_rx_flag_ctrl`

## Requirements
- R1: After reset `chan_en` is 0, and reads of the data register (address 0), the status register (address 1) and the run-status register (address 4) all return 0.
- R2: When `rx_done` is high and the channel is enabled, the data register takes `rx_byte` at that edge and the buffer-full flag (status bit 0) becomes 1.
- R3: A read of address 0 clears buffer-full at that edge, unless an accepted `rx_done` occurs in the same cycle, in which case buffer-full stays 1.
- R4: The overrun flag (status bit 3) is set when an accepted `rx_done` arrives while buffer-full is 1 and address 0 is not read in the same cycle.
- R5: An accepted `rx_done` with `rx_parity_bad` set sets the parity flag (status bit 1). An accepted `rx_done` with `rx_stop_bad` set sets the framing flag (status bit 2).
- R6: Reading the status register leaves every flag unchanged.
- R7: Writing address 2 clears each error flag whose bit is 1 in the write data, using the same bit positions as the status register (1 parity, 2 framing, 3 overrun). A 0 bit leaves its flag unchanged, and bit 0 does not affect buffer-full.
- R8: When a flag is set by an event and cleared by a write in the same cycle, the flag ends up set.
- R9: Writing address 3 with bit 1 (stop) set drives `chan_en` to 0. Writing it with only bit 0 (start) set drives `chan_en` to 1. When both bits are set, stop wins.
- R10: Address 3 always reads 0. Address 4 reads `chan_en` in bit 0.
- R11: While `chan_en` is 0, `rx_done` is ignored: no flag is set and the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | DATA_W | Read data (combinational) |
| rx_done | input | 1 | Receiver core: character complete |
| rx_byte | input | DATA_W | Receiver core: received character |
| rx_parity_bad | input | 1 | Receiver core: parity check failed |
| rx_stop_bad | input | 1 | Receiver core: stop bit was 0 |
| chan_en | output | 1 | Channel running |

## Verification
The bench builds the block with the default `DATA_W` of 8. At that width, random receive bytes are easy to tell apart from the zero-extended status and run-status values that share the read path. Directed steps reach the collisions in a single cycle: a data read with a new arrival, a clear with a new error, and start together with stop. A long seeded random run then mixes arrivals, reads, clears and triggers against a bench model of the flags.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
    localparam int ADDR_W = 3;
    localparam int WR_W   = 4;

    localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIG   = 3'd3;
    localparam logic [ADDR_W-1:0] A_RUN    = 3'd4;

    localparam int B_FULL = 0;
    localparam int B_PAR  = 1;
    localparam int B_FRM  = 2;
    localparam int B_OVR  = 3;
    localparam int B_START = 0;
    localparam int B_STOP  = 1;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
        logic full;
    } rx_flags_t;
endpackage

// File: rtl/rxf_flag_bank.sv
module rxf_flag_bank
    import uart_rxf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_parity_bad,
    input  logic              rx_stop_bad,
    input  logic              data_rd,
    input  logic              clr_wr,
    input  logic [WR_W-1:0]   clr_mask,
    output rx_flags_t         flags_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        rx_flags_t         f;
        logic [DATA_W-1:0] data;
    } bank_t;

    bank_t st_d, st_q;
    logic  take;
    logic  [WR_W-1:0] clr_v;

    always_comb begin
        st_d  = st_q;
        take  = rx_done && chan_en;
        clr_v = clr_wr ? clr_mask : '0;
        if (data_rd)
            st_d.f.full = 1'b0;
        st_d.f.par = st_q.f.par & ~clr_v[B_PAR];
        st_d.f.frm = st_q.f.frm & ~clr_v[B_FRM];
        st_d.f.ovr = st_q.f.ovr & ~clr_v[B_OVR];
        if (take) begin
            st_d.data   = rx_byte;
            st_d.f.full = 1'b1;
            if (rx_parity_bad) st_d.f.par = 1'b1;
            if (rx_stop_bad)   st_d.f.frm = 1'b1;
            if (st_q.f.full && !data_rd) st_d.f.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.f;
    assign data_o  = st_q.data;

    // R4
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && rx_done && flags_o.full && !data_rd) |=> flags_o.ovr);
    // R5 R8
    parity_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && rx_done && rx_parity_bad) |=> flags_o.par);
    // R5 R8
    framing_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && rx_done && rx_stop_bad) |=> flags_o.frm);
    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !(chan_en && rx_done)) |=> !flags_o.full);
    // R11 R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !data_rd && !clr_wr) |=> ($stable(flags_o) && $stable(data_o)));
endmodule

// File: rtl/rxf_run_ctrl.sv
module rxf_run_ctrl
    import uart_rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr,
    input  logic start_bit,
    input  logic stop_bit,
    output logic en_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (trig_wr) begin
            if (stop_bit)       en_d = 1'b0;
            else if (start_bit) en_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    // R9
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && stop_bit) |=> !en_o);
    // R9
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && start_bit && !stop_bit) |=> en_o);
    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_wr |=> $stable(en_o));
endmodule

// File: rtl/rxf_read_mux.sv
module rxf_read_mux
    import uart_rxf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  rx_flags_t         flags,
    input  logic [DATA_W-1:0] data,
    input  logic              en,
    output logic [DATA_W-1:0] rdata
);
    localparam int FLAG_W = $bits(rx_flags_t);

    always_comb begin
        rdata = '0;
        case (addr)
            A_DATA:   rdata = data;
            A_STATUS: rdata[FLAG_W-1:0] = flags;
            A_RUN:    rdata[0] = en;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_flag_ctrl.sv
module uart_rx_flag_ctrl
    import uart_rxf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [3:0]        reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_parity_bad,
    input  logic              rx_stop_bad,
    output logic              chan_en
);
    logic      data_rd, clr_wr, trig_wr;
    rx_flags_t flags;
    logic [DATA_W-1:0] data;

    assign data_rd = reg_rd && (reg_addr == A_DATA);
    assign clr_wr  = reg_wr && (reg_addr == A_CLEAR);
    assign trig_wr = reg_wr && (reg_addr == A_TRIG);

    rxf_flag_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_parity_bad(rx_parity_bad), .rx_stop_bad(rx_stop_bad),
        .data_rd(data_rd), .clr_wr(clr_wr), .clr_mask(reg_wdata),
        .flags_o(flags), .data_o(data)
    );

    rxf_run_ctrl u_run (
        .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr),
        .start_bit(reg_wdata[B_START]), .stop_bit(reg_wdata[B_STOP]),
        .en_o(chan_en)
    );

    rxf_read_mux #(.DATA_W(DATA_W)) u_mux (
        .addr(reg_addr), .flags(flags), .data(data), .en(chan_en),
        .rdata(reg_rdata)
    );
endmodule

// File: tb/uart_rx_flag_ctrl_tb.sv
module uart_rx_flag_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_parity_bad = 1'b0, rx_stop_bad = 1'b0;
    logic       chan_en;

    int checks = 0;
    int failures = 0;

    logic       m_en, m_full, m_par, m_frm, m_ovr;
    logic [7:0] m_data;

    always #10 clk = ~clk;

    uart_rx_flag_ctrl #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_done(rx_done), .rx_byte(rx_byte), .rx_parity_bad(rx_parity_bad),
        .rx_stop_bad(rx_stop_bad), .chan_en(chan_en)
    );

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_data;
            3'd1:    return {4'b0, m_ovr, m_frm, m_par, m_full};
            3'd4:    return {7'b0, m_en};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_for(input logic [2:0] a);
        case (a)
            3'd0:    return "R2";
            3'd1:    return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check read data before the edge, then advance the model.
    task automatic cyc(input logic rx, input logic [7:0] b, input logic pb, input logic sb,
                       input logic rd, input logic wr, input logic [2:0] a,
                       input logic [3:0] wd, input string tag);
        logic take, drd;
        logic [3:0] clr;
        rx_done = rx; rx_byte = b; rx_parity_bad = pb; rx_stop_bad = sb;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        check("R9 chan_en", {7'b0, chan_en}, {7'b0, m_en});
        if (rd) check(tag, reg_rdata, model_read(a));
        @(posedge clk);
        drd  = rd && a == 3'd0;
        clr  = (wr && a == 3'd2) ? wd : 4'b0;
        take = rx && m_en;
        m_par = (m_par & ~clr[1]) | (take & pb);
        m_frm = (m_frm & ~clr[2]) | (take & sb);
        m_ovr = (m_ovr & ~clr[3]) | (take & m_full & ~drd);
        m_full = take ? 1'b1 : (drd ? 1'b0 : m_full);
        if (take) m_data = b;
        if (wr && a == 3'd3) begin
            if (wd[1])      m_en = 1'b0;
            else if (wd[0]) m_en = 1'b1;
        end
        @(negedge clk);
        rx_done = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, a, 4'h0, tag);
    endtask
    task automatic wr_reg(input logic [2:0] a, input logic [3:0] wd);
        cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, a, wd, "wr");
    endtask
    task automatic rx_evt(input logic [7:0] b, input logic pb, input logic sb);
        cyc(1'b1, b, pb, sb, 1'b0, 1'b0, 3'd0, 4'h0, "rx");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_en = 0; m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0; m_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_reg(3'd0, "R1 data");
        rd_reg(3'd1, "R1 status");
        rd_reg(3'd4, "R1 run");
        // R11 stopped channel ignores arrivals
        rx_evt(8'h77, 1'b1, 1'b1);
        rd_reg(3'd1, "R11 status");
        rd_reg(3'd0, "R11 data");
        // R9 start, R10 trigger reads zero
        wr_reg(3'd3, 4'h1);
        rd_reg(3'd4, "R9 start run");
        rd_reg(3'd3, "R10 trig");
        // R2 good byte, R6 repeated status read, R3 data read clears full
        rx_evt(8'hA5, 1'b0, 1'b0);
        rd_reg(3'd1, "R2 status");
        rd_reg(3'd1, "R6 status again");
        rd_reg(3'd0, "R2 data");
        rd_reg(3'd1, "R3 full cleared");
        // R5 R4 error flags
        rx_evt(8'h3C, 1'b1, 1'b0);
        rd_reg(3'd1, "R5 parity");
        rx_evt(8'h5A, 1'b0, 1'b1);
        rd_reg(3'd1, "R4 R5 ovr+frm");
        // R7 clear masks
        wr_reg(3'd2, 4'h2);
        rd_reg(3'd1, "R7 parity cleared");
        wr_reg(3'd2, 4'h0);
        rd_reg(3'd1, "R7 zero write");
        wr_reg(3'd2, 4'hF);
        rd_reg(3'd1, "R7 full kept");
        // R3 data read with same-cycle arrival
        cyc(1'b1, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 4'h0, "R3 data");
        rd_reg(3'd1, "R3 full stays no ovr");
        rd_reg(3'd0, "R3 new data");
        // R8 clear collides with new parity error
        cyc(1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 4'h2, "R8");
        rd_reg(3'd1, "R8 set wins");
        // R9 both triggers: stop wins
        wr_reg(3'd3, 4'h3);
        rd_reg(3'd4, "R9 stop wins");
        rx_evt(8'h99, 1'b0, 1'b1);
        rd_reg(3'd1, "R11 stopped");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] op;
            logic [2:0] a;
            logic rx;
            op = 4'($urandom_range(0, 9));
            a  = 3'($urandom_range(0, 5));
            rx = ($urandom_range(0, 2) == 0);
            case (op)
                4'd0, 4'd1, 4'd2:
                    cyc(rx, 8'($urandom), 1'($urandom), 1'($urandom), 1'b1, 1'b0, a, 4'h0, tag_for(a));
                4'd3:
                    cyc(rx, 8'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b1, 3'd2, 4'($urandom), "R7");
                4'd4:
                    cyc(rx, 8'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b1, 3'd3,
                        ($urandom_range(0, 3) == 0) ? 4'h2 : 4'h1, "R9");
                default:
                    cyc(1'b1, 8'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0, 3'd0, 4'h0, "R4");
            endcase
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule